// File: doc/BRIEF.md
# Serial Transmitter Control with CRC Append

This block sequences characters onto a serial data line. A host writes a six-bit control word and single bytes into a one-deep holding buffer. On each bit-rate enable pulse the block either advances the current character by one bit or, at a character boundary, picks the next one. That next character is a buffered byte, a fill sync pattern, one half of a 16-bit frame check, or nothing, in which case the line idles at one. The bit-rate pulse is generated outside the block.

There are two modes. In asynchronous mode each byte is framed with start and stop bits. In character-synchronous mode a byte goes out as eight bare bits. In this mode the line is never left empty while the transmitter runs: when the buffer runs dry it appends the frame check or fills with sync characters. The block also drives active-low RTS and DTR pins, honours an optional clear-to-send gate, and keeps an end-of-message latch. That latch decides whether the next underrun appends a frame check.

Top module: `tx_serial_ctrl`

## Requirements
- R1: After reset `txd_o`=1, `rts_no`=1, `dtr_no`=1, `buf_empty_o`=1 and `eom_o`=1, and all control bits are zero. The control word fields are: bit 0 transmit enable, bit 1 RTS, bit 2 DTR, bit 3 CRC enable, bit 4 break, bit 5 auto enable.
- R2: In asynchronous mode (`mode_sync_i`=0) a byte is sent as a 0 start bit, then eight data bits LSB first, then a 1 stop bit. Each bit lasts from one `bit_en_i` pulse to the next, and the line rests at 1 between frames.
- R3: With auto enable and transmit enable both set, a new character is taken only while `cts_ni` is 0. With auto enable clear, `cts_ni` has no effect on transmission.
- R4: With break set, `txd_o` is 0 from the cycle after the write, whether or not the transmitter is enabled. The shift position is frozen while break is set. After release, shifting resumes from the frozen contents.
- R5: In synchronous mode the CRC-16 (x^16+x^15+x^2+1, preset 0, fed with each byte LSB first) is updated with a byte only if CRC enable is set in the cycle that byte leaves the buffer. Sync and check characters never enter it.
- R6: In synchronous mode an underrun is a character boundary reached after a data byte with the buffer empty. If the end-of-message latch is clear and CRC enable is set at that boundary, the check goes out high byte then low byte, each LSB first, followed by sync fill. Otherwise sync fill follows directly. Every underrun sets the latch and presets the CRC to zero.
- R7: `dtr_no` is the inverse of the DTR bit. In synchronous mode `rts_no` is the inverse of the RTS bit.
- R8: In asynchronous mode, setting RTS drives `rts_no` low. Clearing it raises `rts_no` only after the current frame has fully shifted out and the buffer is empty.
- R9: Clearing transmit enable lets a data or sync character in flight finish, after which the line idles. If it is cleared while a check character is in flight, a complete sync character starts at the next bit pulse and the rest of the check is dropped.
- R10: The end-of-message latch (`eom_o`) is set by reset, by transmit enable being clear, by an `abort_i` pulse, and by an underrun. It is cleared only by a `clr_eom_i` pulse, and setting wins over clearing.
- R11: A buffer write makes `buf_empty_o` 0 on the next cycle. Moving the byte to the shifter makes it 1 unless a new write lands in the same cycle. In asynchronous mode no CRC is accumulated or appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | One-cycle bit-rate enable |
| mode_sync_i | input | 1 | 0 asynchronous, 1 character-synchronous |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_i | input | 6 | Control word (fields in R1) |
| abort_i | input | 1 | Send-abort command pulse, sets the latch |
| clr_eom_i | input | 1 | Clear end-of-message latch pulse |
| buf_we_i | input | 1 | Transmit buffer write strobe |
| buf_data_i | input | 8 | Byte to transmit |
| sync_pat_i | input | 8 | Sync fill character |
| cts_ni | input | 1 | Clear to send, active low |
| txd_o | output | 1 | Serial data |
| rts_no | output | 1 | Request to send, active low |
| dtr_no | output | 1 | Data terminal ready, active low |
| buf_empty_o | output | 1 | Transmit buffer empty |
| eom_o | output | 1 | End-of-message / underrun latch |

## Verification
A wrong bit counter or a wrong boundary decision appears on `txd_o` within one bit period, as a start, stop or data bit in the wrong place. A corrupted CRC register stays hidden until the next underrun, when the two check bytes go out wrong. A stuck latch shows at once on `eom_o`, and one message later as a missing or surplus check. An RTS hold fault in asynchronous mode moves the `rts_no` rising edge away from the last stop bit. It therefore shows up only when RTS is cleared mid-frame.

// File: rtl/tx_pkg.sv
`timescale 1ns/1ps
package tx_pkg;
  typedef struct packed {
    logic auto_en;
    logic brk;
    logic crc_en;
    logic dtr;
    logic rts;
    logic tx_en;
  } tx_ctrl_t;

  typedef enum logic [1:0] {K_DATA, K_SYNC, K_CRC_HI, K_CRC_LO} char_kind_e;

  typedef enum logic [2:0] {SEL_IDLE, SEL_DATA, SEL_SYNC, SEL_CRC_HI, SEL_CRC_LO} char_sel_e;
endpackage

// File: rtl/tx_ctrl_regs.sv
`timescale 1ns/1ps
module tx_ctrl_regs
  import tx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ctrl_we_i,
  input  tx_ctrl_t ctrl_i,
  input  logic     abort_i,
  input  logic     clr_eom_i,
  input  logic     underrun_i,
  input  logic     mode_sync_i,
  input  logic     line_quiet_i,
  output tx_ctrl_t ctrl_o,
  output logic     eom_o,
  output logic     rts_no,
  output logic     dtr_no
);
  tx_ctrl_t ctrl_q;
  logic     eom_q;
  logic     hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_i;
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eom_q <= 1'b1;
    else if (!ctrl_q.tx_en || abort_i || underrun_i) eom_q <= 1'b1;
    else if (clr_eom_i) eom_q <= 1'b0;
  end

  // async-mode RTS keeps the pin asserted until the line drains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else hold_q <= !mode_sync_i && (ctrl_q.rts || (hold_q && !line_quiet_i));
  end

  assign ctrl_o = ctrl_q;
  assign eom_o  = eom_q;
  assign rts_no = !(ctrl_q.rts || hold_q);
  assign dtr_no = !ctrl_q.dtr;

  a_r10_disable_sets_eom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.tx_en |=> eom_q);
  a_r10_eom_clear_by_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eom_q) |-> $past(clr_eom_i));
  a_r8_rts_held_until_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_sync_i && !rts_no && !line_quiet_i) |=> !rts_no);
endmodule

// File: rtl/tx_crc16.sv
`timescale 1ns/1ps
module tx_crc16 #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8005
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q, crc_nxt;

  // byte folded in LSB first, one step per bit
  always_comb begin
    logic fb;
    crc_nxt = crc_q;
    for (int i = 0; i < DATA_W; i++) begin
      fb      = crc_nxt[CRC_W-1] ^ data_i[i];
      crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (acc_i) crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;

  a_r5_crc_holds_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !clr_i) |=> $stable(crc_q));
  a_r6_crc_preset_on_underrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_q == '0));
endmodule

// File: rtl/tx_shifter.sv
`timescale 1ns/1ps
module tx_shifter
  import tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SH_W  = DATA_W + 2,
  localparam int unsigned CNT_W = $clog2(SH_W),
  localparam int unsigned CRC_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              mode_sync_i,
  input  logic              go_i,
  input  logic              tx_en_i,
  input  logic              brk_i,
  input  logic              crc_en_i,
  input  logic              eom_i,
  input  logic              buf_full_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  logic [DATA_W-1:0] sync_pat_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              take_o,
  output logic              crc_acc_o,
  output logic              underrun_o,
  output logic              txd_o,
  output logic              idle_o
);
  logic              active_q;
  char_kind_e        kind_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_data_q;
  logic [DATA_W-1:0] crc_lo_q;

  logic [CNT_W-1:0]  last_idx;
  logic              step, is_crc, abandon, boundary, fire, und_c;
  char_sel_e         sel;

  assign last_idx = mode_sync_i ? CNT_W'(DATA_W - 1) : CNT_W'(SH_W - 1);
  assign step     = bit_en_i && !brk_i;
  assign is_crc   = (kind_q == K_CRC_HI) || (kind_q == K_CRC_LO);
  assign abandon  = active_q && is_crc && !tx_en_i;
  assign boundary = !active_q || (cnt_q == last_idx);
  assign fire     = step && !abandon && boundary;

  always_comb begin
    und_c = 1'b0;
    if (!go_i)                                 sel = SEL_IDLE;
    else if (buf_full_i)                       sel = SEL_DATA;
    else if (!mode_sync_i)                     sel = SEL_IDLE;
    else if (active_q && kind_q == K_CRC_HI)   sel = SEL_CRC_LO;
    else if (active_q && last_data_q) begin
      und_c = 1'b1;
      sel   = (!eom_i && crc_en_i) ? SEL_CRC_HI : SEL_SYNC;
    end
    else                                       sel = SEL_SYNC;
  end

  assign take_o     = fire && (sel == SEL_DATA);
  assign crc_acc_o  = take_o && mode_sync_i && crc_en_i;
  assign underrun_o = fire && und_c;

  function automatic logic [SH_W-1:0] data_frame(input logic [DATA_W-1:0] d, input logic sync);
    return sync ? {2'b11, d} : {1'b1, d, 1'b0};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      kind_q      <= K_SYNC;
      sh_q        <= '1;
      cnt_q       <= '0;
      last_data_q <= 1'b0;
      crc_lo_q    <= '0;
    end else if (step) begin
      if (abandon) begin
        sh_q        <= {2'b11, sync_pat_i};
        kind_q      <= K_SYNC;
        cnt_q       <= '0;
        last_data_q <= 1'b0;
      end else if (!boundary) begin
        sh_q  <= {1'b1, sh_q[SH_W-1:1]};
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        cnt_q <= '0;
        unique case (sel)
          SEL_DATA: begin
            sh_q        <= data_frame(buf_data_i, mode_sync_i);
            kind_q      <= K_DATA;
            active_q    <= 1'b1;
            last_data_q <= 1'b1;
          end
          SEL_SYNC: begin
            sh_q        <= {2'b11, sync_pat_i};
            kind_q      <= K_SYNC;
            active_q    <= 1'b1;
            last_data_q <= 1'b0;
          end
          SEL_CRC_HI: begin
            sh_q        <= {2'b11, crc_i[CRC_W-1:DATA_W]};
            crc_lo_q    <= crc_i[DATA_W-1:0];
            kind_q      <= K_CRC_HI;
            active_q    <= 1'b1;
            last_data_q <= 1'b0;
          end
          SEL_CRC_LO: begin
            sh_q        <= {2'b11, crc_lo_q};
            kind_q      <= K_CRC_LO;
            active_q    <= 1'b1;
            last_data_q <= 1'b0;
          end
          default: begin
            active_q    <= 1'b0;
            last_data_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign txd_o  = active_q ? sh_q[0] : 1'b1;
  assign idle_o = !active_q;

  a_r4_break_freezes_shifter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> ($stable(sh_q) && $stable(cnt_q) && $stable(active_q)));
  a_r9_no_check_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && step) |=> !(active_q && is_crc));
  a_r2_count_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !mode_sync_i && $stable(mode_sync_i)) |-> (cnt_q <= CNT_W'(SH_W - 1)));
endmodule

// File: rtl/tx_serial_ctrl.sv
`timescale 1ns/1ps
module tx_serial_ctrl
  import tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CRC_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              mode_sync_i,
  input  logic              ctrl_we_i,
  input  logic [5:0]        ctrl_i,
  input  logic              abort_i,
  input  logic              clr_eom_i,
  input  logic              buf_we_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  logic [DATA_W-1:0] sync_pat_i,
  input  logic              cts_ni,
  output logic              txd_o,
  output logic              rts_no,
  output logic              dtr_no,
  output logic              buf_empty_o,
  output logic              eom_o
);
  tx_ctrl_t          ctrl;
  logic              eom;
  logic              buf_full_q;
  logic [DATA_W-1:0] buf_q;
  logic              take, crc_acc, underrun, line_bit, shift_idle, go;
  logic [CRC_W-1:0]  crc;

  assign go = ctrl.tx_en && (!ctrl.auto_en || !cts_ni) && !ctrl.brk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_full_q <= 1'b0;
      buf_q      <= '0;
    end else if (buf_we_i) begin
      buf_full_q <= 1'b1;
      buf_q      <= buf_data_i;
    end else if (take) begin
      buf_full_q <= 1'b0;
    end
  end

  tx_ctrl_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_i       (tx_ctrl_t'(ctrl_i)),
    .abort_i      (abort_i),
    .clr_eom_i    (clr_eom_i),
    .underrun_i   (underrun),
    .mode_sync_i  (mode_sync_i),
    .line_quiet_i (shift_idle && !buf_full_q),
    .ctrl_o       (ctrl),
    .eom_o        (eom),
    .rts_no       (rts_no),
    .dtr_no       (dtr_no)
  );

  tx_crc16 #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (crc_acc),
    .clr_i  (underrun),
    .data_i (buf_q),
    .crc_o  (crc)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .mode_sync_i (mode_sync_i),
    .go_i        (go),
    .tx_en_i     (ctrl.tx_en),
    .brk_i       (ctrl.brk),
    .crc_en_i    (ctrl.crc_en),
    .eom_i       (eom),
    .buf_full_i  (buf_full_q),
    .buf_data_i  (buf_q),
    .sync_pat_i  (sync_pat_i),
    .crc_i       (crc),
    .take_o      (take),
    .crc_acc_o   (crc_acc),
    .underrun_o  (underrun),
    .txd_o       (line_bit),
    .idle_o      (shift_idle)
  );

  assign txd_o       = ctrl.brk ? 1'b0 : line_bit;
  assign buf_empty_o = !buf_full_q;
  assign eom_o       = eom;

  a_r3_cts_gates_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && ctrl.auto_en) |-> !cts_ni);
  a_r11_take_empties_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !buf_we_i) |=> buf_empty_o);
  a_r11_write_fills_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i |=> !buf_empty_o);
  a_r11_no_crc_async: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_sync_i |-> !(crc_acc || underrun));
endmodule

// File: tb/tx_serial_ctrl_bench.sv
`timescale 1ns/1ps
module tx_serial_ctrl_bench;
  localparam int TXEN = 1, RTS = 2, DTR = 4, CRCEN = 8, BRK = 16, AUTO = 32;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       mode_sync_i = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [5:0] ctrl_i = '0;
  logic       abort_i = 1'b0;
  logic       clr_eom_i = 1'b0;
  logic       buf_we_i = 1'b0;
  logic [7:0] buf_data_i = '0;
  logic [7:0] sync_pat_i = 8'h16;
  logic       cts_ni = 1'b1;
  logic       txd_o, rts_no, dtr_no, buf_empty_o, eom_o;

  tx_serial_ctrl u_tx_serial_ctrl (.*);

  always #2.5 clk_i = ~clk_i;

  int    checks = 0, fails = 0, cyc = 0, div = 0;
  bit    done = 0, bit_run = 1;
  string cur_req = "R1";

  // reference model state
  bit   bitq[$];
  int   m_kind, m_ctrl, m_crc, m_crc_lo, m_buf;
  bit   m_eom, m_hold, m_full, m_last;

  function automatic int crc_upd(int c, int d);
    for (int i = 0; i < 8; i++) begin
      bit fb = ((c >> 15) & 1) ^ ((d >> i) & 1);
      c = (c << 1) & 16'hFFFF;
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  task automatic push_char(int v, bit framed);
    if (framed) bitq.push_back(1'b0);
    for (int i = 0; i < 8; i++) bitq.push_back(bit'((v >> i) & 1));
    if (framed) bitq.push_back(1'b1);
  endtask

  task automatic model_reset();
    bitq.delete();
    m_kind = 1; m_ctrl = 0; m_crc = 0; m_crc_lo = 0; m_buf = 0;
    m_eom = 1; m_hold = 0; m_full = 0; m_last = 0;
  endtask

  task automatic model_step();
    bit txen = m_ctrl[0], rts = m_ctrl[1], crcen = m_ctrl[3];
    bit brk = m_ctrl[4], auto_e = m_ctrl[5];
    bit quiet = (bitq.size() == 0) && !m_full;
    bit took = 0, und = 0, was_act;
    if (bit_en_i && !brk) begin
      was_act = bitq.size() != 0;
      if (was_act && (m_kind == 2 || m_kind == 3) && !txen) begin
        bitq.delete(); push_char(sync_pat_i, 0); m_kind = 1; m_last = 0;
      end else begin
        if (was_act) void'(bitq.pop_front());
        if (bitq.size() == 0) begin
          if (!(txen && (!auto_e || !cts_ni))) m_last = 0;
          else if (m_full) begin
            push_char(m_buf, !mode_sync_i); took = 1;
            if (mode_sync_i && crcen) m_crc = crc_upd(m_crc, m_buf);
            m_kind = 0; m_last = 1;
          end
          else if (!mode_sync_i) m_last = 0;
          else if (was_act && m_kind == 2) begin
            push_char(m_crc_lo, 0); m_kind = 3; m_last = 0;
          end
          else if (was_act && m_last) begin
            int v = m_crc;
            und = 1; m_crc = 0; m_last = 0;
            if (!m_eom && crcen) begin
              push_char(v >> 8, 0); m_crc_lo = v & 8'hFF; m_kind = 2;
            end else begin
              push_char(sync_pat_i, 0); m_kind = 1;
            end
          end
          else begin
            push_char(sync_pat_i, 0); m_kind = 1; m_last = 0;
          end
        end
      end
    end
    if (!txen || abort_i || und) m_eom = 1;
    else if (clr_eom_i) m_eom = 0;
    m_hold = !mode_sync_i && (rts || (m_hold && !quiet));
    if (buf_we_i) begin m_full = 1; m_buf = buf_data_i; end
    else if (took) m_full = 0;
    if (ctrl_we_i) m_ctrl = ctrl_i;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else model_step();
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(cur_req, "txd",   txd_o, m_ctrl[4] ? 0 : (bitq.size() != 0 ? int'(bitq[0]) : 1));
      check(cur_req, "rts_n", rts_no, !(m_ctrl[1] || m_hold));
      check("R7",    "dtr_n", dtr_no, !m_ctrl[2]);
      check(cur_req, "empty", buf_empty_o, !m_full);
      check(cur_req, "eom",   eom_o, m_eom);
    end
  end

  // bit-rate pulse every 4 clocks
  always @(negedge clk_i) begin
    div = (div + 1) % 4;
    bit_en_i = bit_run && (div == 0);
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_ctrl(int v);
    @(negedge clk_i); ctrl_we_i = 1; ctrl_i = 6'(v);
    @(negedge clk_i); ctrl_we_i = 0;
  endtask

  task automatic pulse_abort();
    @(negedge clk_i); abort_i = 1; @(negedge clk_i); abort_i = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk_i); clr_eom_i = 1; @(negedge clk_i); clr_eom_i = 0;
  endtask

  task automatic send(int d);
    while (!buf_empty_o) @(negedge clk_i);
    @(negedge clk_i); buf_we_i = 1; buf_data_i = 8'(d);
    @(negedge clk_i); buf_we_i = 0;
  endtask

  task automatic drain();
    while (!buf_empty_o || bitq.size() != 0) @(negedge clk_i);
    tick(4);
  endtask

  initial begin
    tick(3);
    rst_ni = 1;
    tick(1);
    // R1 reset state
    check("R1", "txd", txd_o, 1);
    check("R1", "rts_n", rts_no, 1);
    check("R1", "dtr_n", dtr_no, 1);
    check("R1", "empty", buf_empty_o, 1);
    check("R1", "eom", eom_o, 1);

    // R11 write while disabled
    cur_req = "R11";
    send(8'h5A);
    check("R11", "empty after write", buf_empty_o, 0);
    tick(20);
    check("R11", "held while disabled", buf_empty_o, 0);

    // R7 pins
    cur_req = "R7";
    wr_ctrl(DTR);
    check("R7", "dtr set", dtr_no, 0);
    mode_sync_i = 1;
    wr_ctrl(DTR | RTS);
    check("R7", "sync rts set", rts_no, 0);
    wr_ctrl(DTR);
    check("R7", "sync rts clear", rts_no, 1);
    wr_ctrl(0);
    check("R7", "dtr clear", dtr_no, 1);
    mode_sync_i = 0;

    // R2 async framing, R8 delayed RTS release
    cur_req = "R2";
    wr_ctrl(TXEN | RTS);
    send(8'hA5);
    send(8'h3C);
    cur_req = "R8";
    tick(8);
    wr_ctrl(TXEN);
    check("R8", "rts held mid-frame", rts_no, 0);
    drain();
    check("R8", "rts released after drain", rts_no, 1);

    // R3 CTS gating
    cur_req = "R3";
    cts_ni = 1;
    wr_ctrl(TXEN | AUTO);
    send(8'hC3);
    tick(80);
    check("R3", "blocked by cts high", buf_empty_o, 0);
    cts_ni = 0;
    drain();
    check("R3", "taken with cts low", buf_empty_o, 1);
    cts_ni = 1;
    wr_ctrl(TXEN);
    send(8'h81);
    drain();
    check("R3", "cts ignored without auto", buf_empty_o, 1);

    // R4 break
    cur_req = "R4";
    send(8'hF0);
    tick(14);
    wr_ctrl(TXEN | BRK);
    check("R4", "txd forced low", txd_o, 0);
    tick(40);
    wr_ctrl(TXEN);
    drain();
    wr_ctrl(BRK);
    check("R4", "low while disabled", txd_o, 0);
    tick(12);
    wr_ctrl(0);
    check("R4", "released idle", txd_o, 1);

    // R10 latch
    cur_req = "R10";
    wr_ctrl(TXEN);
    pulse_clr();
    check("R10", "cleared by command", eom_o, 0);
    pulse_abort();
    check("R10", "set by abort", eom_o, 1);
    pulse_clr();
    wr_ctrl(0);
    tick(1);
    check("R10", "set by disable", eom_o, 1);
    pulse_clr();
    check("R10", "clear loses to disable", eom_o, 1);

    // R5/R6 synchronous with CRC
    mode_sync_i = 1;
    cur_req = "R5";
    wr_ctrl(TXEN | CRCEN | RTS);
    pulse_clr();
    send(8'h31);
    send(8'h32);
    wr_ctrl(TXEN | RTS);
    send(8'h33);
    tick(2);
    wr_ctrl(TXEN | CRCEN | RTS);
    send(8'h34);
    cur_req = "R6";
    tick(200);
    check("R6", "latch set by underrun", eom_o, 1);
    send(8'h55);
    tick(120);
    send(8'hE7);
    pulse_clr();
    tick(150);

    // R9 disable during check
    cur_req = "R9";
    pulse_clr();
    send(8'h01);
    send(8'h02);
    while (!(m_kind == 2 && bitq.size() != 0)) @(negedge clk_i);
    tick(6);
    wr_ctrl(RTS);
    tick(120);
    check("R9", "line idle after disable", txd_o, 1);
    wr_ctrl(TXEN);
    tick(40);
    wr_ctrl(0);
    tick(60);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule